// File: doc/BRIEF.md
# Rename Stage Control State Machine

This block is the per-thread control state machine of a register-rename pipeline stage. Each cycle it takes the status of the stage's surroundings and decides what the stage is doing: idle, renaming, stalled, draining its skid buffer, recovering from a squash, or holding a serializing instruction until the reorder buffer is empty. It also produces the one-cycle block and unblock pulses that hold or release the decode stage upstream. The skid buffer and the rename datapath are outside the block. Only their status flags come in.

The next state is chosen in strict priority. A squash request comes first, then a reorder buffer that is still squashing, then the stall check, and last the normal transition of the current state. Block and unblock pulses from the execute and commit stages are kept as two sticky stall bits. A squash that hits a pending serializing instruction either keeps the serialize wait or drops it, depending on how the two sequence numbers compare.

All outputs are registered. A decision made from the inputs of one cycle appears on the outputs after the next rising clock edge.

Top module: `rename_ctl`

## Requirements
- R1: After reset, `state` is Idle (code 0). `up_block`, `up_unblock`, `reinsert` and `proto_err` are all 0. State codes: Idle 0, Running 1, Blocked 2, Unblocking 3, Squashing 4, SerializeStall 5.
- R2: A `squash_req` moves the stage to Squashing on the next cycle, whatever the other inputs are.
- R3: With no squash request, `rob_squashing` moves the stage to Squashing, or keeps it there.
- R4: The stage is stalled when any of these holds: a sticky stall bit is set (after this cycle's pulses); a ROB, IQ or LSQ credit (two's complement) is zero or negative; `no_free_regs` is high; or the state is SerializeStall while `rob_empty` is low or `inflight` is non-zero. A stall with no squash and no reorder-buffer squash moves Idle, Running or Squashing to Blocked, with a one-cycle `up_block` pulse.
- R5: A stall seen in Blocked or Unblocking gives Blocked with no `up_block` pulse. A stall seen in SerializeStall keeps SerializeStall, never Blocked, with no pulse.
- R6: With no stall, Blocked moves to Unblocking. Unblocking moves to Running with a one-cycle `up_unblock` pulse when `skid_empty` is high, and otherwise stays in Unblocking.
- R7: A block pulse from a source sets that source's sticky stall bit. An unblock pulse clears it. If both arrive in the same cycle, the block wins.
- R8: An unblock pulse that arrives while its source's sticky bit is clear raises that source's `proto_err` bit for one cycle. Bit 0 is execute and bit 1 is commit.
- R9: With no stall, `ser_req` in Idle or Running moves the stage to SerializeStall and pulses `up_block`. The stage latches `ser_req_seq`. In any other state `ser_req` has no effect.
- R10: SerializeStall with no stall moves to Unblocking. For one cycle, `reinsert` is high and `reinsert_seq` carries the latched sequence number.
- R11: A squash in SerializeStall, or in Squashing while a serialize is pending, keeps the serialize when the held number is at most `squash_seq`: the stage leaves Squashing to SerializeStall with an `up_block` pulse. Otherwise the held instruction is dropped, `up_unblock` pulses, and the stage leaves Squashing to Running.
- R12: A squash in Blocked or Unblocking pulses `up_unblock` and drops any pending serialize. A squash that came from Unblocking leaves Squashing to Unblocking with an `up_block` pulse.
- R13: A stall seen in Squashing while a serialize is pending moves the stage to SerializeStall, not Blocked, with an `up_block` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| squash_req | input | 1 | Squash request for this thread |
| squash_seq | input | SEQ_W | Youngest surviving sequence number of the squash |
| rob_squashing | input | 1 | Reorder buffer is still squashing |
| exe_block | input | 1 | Block pulse from execute |
| exe_unblock | input | 1 | Unblock pulse from execute |
| cmt_block | input | 1 | Block pulse from commit |
| cmt_unblock | input | 1 | Unblock pulse from commit |
| rob_credit | input | CRED_W | Free reorder-buffer entries, signed |
| iq_credit | input | CRED_W | Free issue-queue entries, signed |
| lsq_credit | input | CRED_W | Free load/store-queue entries, signed |
| no_free_regs | input | 1 | No physical register is free |
| rob_empty | input | 1 | Reorder buffer is empty |
| inflight | input | CNT_W | Renamed instructions not yet dispatched |
| skid_empty | input | 1 | Skid buffer holds nothing |
| inst_valid | input | 1 | Instructions are waiting to be renamed |
| ser_req | input | 1 | A serialize-before instruction is at the head |
| ser_req_seq | input | SEQ_W | Sequence number of that instruction |
| state | output | 3 | Current state code |
| up_block | output | 1 | Block pulse to decode |
| up_unblock | output | 1 | Unblock pulse to decode |
| reinsert | output | 1 | Put the held instruction back at the queue head |
| reinsert_seq | output | SEQ_W | Sequence number of the reinserted instruction |
| proto_err | output | 2 | Unblock without a matching block (bit 0 execute, bit 1 commit) |

## Verification
Directed sequences cover each stall source alone: a credit at zero, a negative credit, a sticky bit from each stage, and a reorder buffer that is not yet empty during a serialize wait. Comparing these shows whether a wrong pulse comes from the stall check or from the state's own history. Squashes land in every state. For a pending serialize, the squash number is placed equal to, above and below the held number, which separates the resume path from the drop path at the boundary. Long random runs then overlap squashes, stalls, pulses and serialize requests in the same cycle, so the priority order is tried in combinations no directed case reaches.

// File: rtl/rn_ctl_pkg.sv
package rn_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RUN     = 3'd1,
        ST_BLOCKED = 3'd2,
        ST_UNBLK   = 3'd3,
        ST_SQUASH  = 3'd4,
        ST_SERIAL  = 3'd5
    } rn_state_e;

    localparam int NUM_SRC = 2;   // sticky stall sources
    localparam int SRC_EXE = 0;
    localparam int SRC_CMT = 1;

endpackage

// File: rtl/rn_stall_src.sv
// One sticky stall bit fed by block/unblock pulses from a downstream stage.
module rn_stall_src (
    input  logic clk,
    input  logic rst_n,
    input  logic blk_i,
    input  logic unblk_i,
    output logic held_o,   // bit value after this cycle's pulses
    output logic err_o     // registered: unblock seen while bit clear
);

    logic sticky_q, sticky_d;
    logic err_q, err_d;

    always_comb begin
        sticky_d = sticky_q;
        if (unblk_i) sticky_d = 1'b0;
        if (blk_i)   sticky_d = 1'b1;   // block wins
        err_d = unblk_i & ~sticky_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sticky_q <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            sticky_q <= sticky_d;
            err_q    <= err_d;
        end
    end

    assign held_o = sticky_d;
    assign err_o  = err_q;

    // R7: a block pulse leaves the bit set on the following cycle
    a_r7_block_sets: assert property (@(posedge clk) disable iff (!rst_n)
        blk_i |=> sticky_q);

    // R7: unblock alone leaves the bit clear on the following cycle
    a_r7_unblock_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (unblk_i && !blk_i) |=> !sticky_q);

endmodule

// File: rtl/rn_stall_eval.sv
// Combines every stall cause into one flag.
module rn_stall_eval #(
    parameter int CRED_W  = 8,
    parameter int CNT_W   = 6,
    parameter int NUM_SRC = 2
) (
    input  logic [NUM_SRC-1:0]       held_i,
    input  logic signed [CRED_W-1:0] rob_credit_i,
    input  logic signed [CRED_W-1:0] iq_credit_i,
    input  logic signed [CRED_W-1:0] lsq_credit_i,
    input  logic                     no_free_regs_i,
    input  logic                     in_serial_i,
    input  logic                     rob_empty_i,
    input  logic [CNT_W-1:0]         inflight_i,
    output logic                     stall_o
);

    localparam int NUM_CRED = 3;

    logic [NUM_CRED-1:0] cred_out;
    logic [CRED_W-1:0]   cred_v [NUM_CRED];

    always_comb begin
        cred_v[0] = rob_credit_i;
        cred_v[1] = iq_credit_i;
        cred_v[2] = lsq_credit_i;
    end

    for (genvar c = 0; c < NUM_CRED; c++) begin : g_cred
        // exhausted when negative or zero
        assign cred_out[c] = cred_v[c][CRED_W-1] || (cred_v[c] == '0);
    end

    logic serial_wait;
    assign serial_wait = in_serial_i && (!rob_empty_i || (inflight_i != '0));

    assign stall_o = (|held_i) || (|cred_out) || no_free_regs_i || serial_wait;

endmodule

// File: rtl/rename_ctl.sv
module rename_ctl
    import rn_ctl_pkg::*;
#(
    parameter int SEQ_W  = 16,
    parameter int CNT_W  = 6,
    parameter int CRED_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     squash_req,
    input  logic [SEQ_W-1:0]         squash_seq,
    input  logic                     rob_squashing,
    input  logic                     exe_block,
    input  logic                     exe_unblock,
    input  logic                     cmt_block,
    input  logic                     cmt_unblock,
    input  logic signed [CRED_W-1:0] rob_credit,
    input  logic signed [CRED_W-1:0] iq_credit,
    input  logic signed [CRED_W-1:0] lsq_credit,
    input  logic                     no_free_regs,
    input  logic                     rob_empty,
    input  logic [CNT_W-1:0]         inflight,
    input  logic                     skid_empty,
    input  logic                     inst_valid,
    input  logic                     ser_req,
    input  logic [SEQ_W-1:0]         ser_req_seq,
    output logic [2:0]               state,
    output logic                     up_block,
    output logic                     up_unblock,
    output logic                     reinsert,
    output logic [SEQ_W-1:0]         reinsert_seq,
    output logic [NUM_SRC-1:0]       proto_err
);

    typedef struct packed {
        rn_state_e        st;
        logic             blk;        // block pulse upstream
        logic             unblk;      // unblock pulse upstream
        logic             ser_held;   // serializing instruction pending
        logic [SEQ_W-1:0] ser_seq;
        logic             res_ser;    // resume serialize after squash
        logic             res_unblk;  // resume unblocking after squash
        logic             reins;
        logic [SEQ_W-1:0] reins_seq;
    } ctl_t;

    localparam ctl_t CTL_RST = '{st: ST_IDLE, default: '0};

    ctl_t q, d;

    // ---------------- sticky stall sources ----------------
    logic [NUM_SRC-1:0] blk_v, unb_v, held_v, err_v;
    assign blk_v[SRC_EXE] = exe_block;
    assign blk_v[SRC_CMT] = cmt_block;
    assign unb_v[SRC_EXE] = exe_unblock;
    assign unb_v[SRC_CMT] = cmt_unblock;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        rn_stall_src u_src (
            .clk     (clk),
            .rst_n   (rst_n),
            .blk_i   (blk_v[s]),
            .unblk_i (unb_v[s]),
            .held_o  (held_v[s]),
            .err_o   (err_v[s])
        );
    end

    // ---------------- stall evaluation ----------------
    logic stall;

    rn_stall_eval #(
        .CRED_W  (CRED_W),
        .CNT_W   (CNT_W),
        .NUM_SRC (NUM_SRC)
    ) u_stall (
        .held_i         (held_v),
        .rob_credit_i   (rob_credit),
        .iq_credit_i    (iq_credit),
        .lsq_credit_i   (lsq_credit),
        .no_free_regs_i (no_free_regs),
        .in_serial_i    (q.st == ST_SERIAL),
        .rob_empty_i    (rob_empty),
        .inflight_i     (inflight),
        .stall_o        (stall)
    );

    // ---------------- next-state logic ----------------
    always_comb begin
        d       = q;
        d.blk   = 1'b0;
        d.unblk = 1'b0;
        d.reins = 1'b0;

        if (squash_req) begin
            d.st = ST_SQUASH;
            unique case (q.st)
                ST_BLOCKED, ST_UNBLK: begin
                    d.unblk     = 1'b1;
                    d.ser_held  = 1'b0;
                    d.res_ser   = 1'b0;
                    d.res_unblk = (q.st == ST_UNBLK);
                end
                ST_SERIAL, ST_SQUASH: begin
                    if (q.ser_held) begin
                        if (q.ser_seq <= squash_seq) begin
                            d.res_ser = 1'b1;
                        end else begin
                            d.res_ser  = 1'b0;
                            d.ser_held = 1'b0;
                            d.unblk    = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end else if (rob_squashing) begin
            d.st = ST_SQUASH;
        end else if (stall) begin
            if (q.st == ST_SQUASH && q.res_ser) begin
                d.st        = ST_SERIAL;
                d.res_ser   = 1'b0;
                d.res_unblk = 1'b0;
                d.blk       = 1'b1;
            end else if (q.st != ST_SERIAL) begin
                d.st        = ST_BLOCKED;
                d.blk       = (q.st != ST_BLOCKED) && (q.st != ST_UNBLK);
                d.res_unblk = 1'b0;
            end
        end else begin
            unique case (q.st)
                ST_IDLE, ST_RUN: begin
                    if (ser_req) begin
                        d.st       = ST_SERIAL;
                        d.ser_held = 1'b1;
                        d.ser_seq  = ser_req_seq;
                        d.blk      = 1'b1;
                    end else if (inst_valid) begin
                        d.st = ST_RUN;
                    end
                end
                ST_BLOCKED: d.st = ST_UNBLK;
                ST_UNBLK: begin
                    if (skid_empty) begin
                        d.st    = ST_RUN;
                        d.unblk = 1'b1;
                    end
                end
                ST_SQUASH: begin
                    if (q.res_ser) begin
                        d.st      = ST_SERIAL;
                        d.res_ser = 1'b0;
                        d.blk     = 1'b1;
                    end else if (q.res_unblk) begin
                        d.st        = ST_UNBLK;
                        d.res_unblk = 1'b0;
                        d.blk       = 1'b1;
                    end else begin
                        d.st = ST_RUN;
                    end
                end
                ST_SERIAL: begin
                    d.st        = ST_UNBLK;
                    d.reins     = 1'b1;
                    d.reins_seq = q.ser_seq;
                    d.ser_held  = 1'b0;
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CTL_RST;
        else        q <= d;
    end

    assign state        = q.st;
    assign up_block     = q.blk;
    assign up_unblock   = q.unblk;
    assign reinsert     = q.reins;
    assign reinsert_seq = q.reins_seq;
    assign proto_err    = err_v;

    // ---------------- assertions ----------------
    // R1: block and unblock are never sent upstream together
    a_r1_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_block && up_unblock));

    // R2: squash always lands in Squashing
    a_r2_squash_wins: assert property (@(posedge clk) disable iff (!rst_n)
        squash_req |=> (state == ST_SQUASH));

    // R5: no repeated block pulse while already Blocked
    a_r5_no_reblock: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BLOCKED) |=> !up_block);

    // R5: serialize wait is never turned into Blocked
    a_r5_serial_not_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SERIAL) |=> (state != ST_BLOCKED));

    // R10: a reinsert only happens on the way out of SerializeStall
    a_r10_reinsert_exit: assert property (@(posedge clk) disable iff (!rst_n)
        reinsert |-> ((state == ST_UNBLK) && ($past(state) == ST_SERIAL)));

    // R6: entering Running from Unblocking always releases decode
    a_r6_unblock_release: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_UNBLK) && !squash_req && !rob_squashing && !stall && skid_empty)
        |=> up_unblock);

endmodule

// File: tb/rename_ctl_tb_top.sv
module rename_ctl_tb_top;

    localparam int SEQ_W  = 16;
    localparam int CNT_W  = 6;
    localparam int CRED_W = 8;

    localparam logic [2:0] S_IDLE = 3'd0, S_RUN = 3'd1, S_BLK = 3'd2,
                           S_UNB = 3'd3, S_SQ = 3'd4, S_SER = 3'd5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic                     squash_req, rob_squashing;
    logic [SEQ_W-1:0]         squash_seq, ser_req_seq;
    logic                     exe_block, exe_unblock, cmt_block, cmt_unblock;
    logic signed [CRED_W-1:0] rob_credit, iq_credit, lsq_credit;
    logic                     no_free_regs, rob_empty, skid_empty, inst_valid, ser_req;
    logic [CNT_W-1:0]         inflight;
    logic [2:0]               state;
    logic                     up_block, up_unblock, reinsert;
    logic [SEQ_W-1:0]         reinsert_seq;
    logic [1:0]               proto_err;

    rename_ctl #(.SEQ_W(SEQ_W), .CNT_W(CNT_W), .CRED_W(CRED_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .squash_req(squash_req), .squash_seq(squash_seq),
        .rob_squashing(rob_squashing), .exe_block(exe_block), .exe_unblock(exe_unblock),
        .cmt_block(cmt_block), .cmt_unblock(cmt_unblock), .rob_credit(rob_credit),
        .iq_credit(iq_credit), .lsq_credit(lsq_credit), .no_free_regs(no_free_regs),
        .rob_empty(rob_empty), .inflight(inflight), .skid_empty(skid_empty),
        .inst_valid(inst_valid), .ser_req(ser_req), .ser_req_seq(ser_req_seq),
        .state(state), .up_block(up_block), .up_unblock(up_unblock),
        .reinsert(reinsert), .reinsert_seq(reinsert_seq), .proto_err(proto_err)
    );

    int n_tests = 0;
    int n_fail  = 0;

    // ---------------- reference model ----------------
    logic [2:0]       m_st;
    logic             m_blk, m_unb, m_rein, m_held, m_rser, m_runb;
    logic [SEQ_W-1:0] m_seq, m_rseq;
    logic [1:0]       m_stk, m_perr;
    string            m_tag;

    task automatic model_reset();
        m_st = S_IDLE; m_blk = 0; m_unb = 0; m_rein = 0; m_held = 0;
        m_rser = 0; m_runb = 0; m_seq = '0; m_rseq = '0; m_stk = 2'b00; m_perr = 2'b00;
        m_tag = "R1";
    endtask

    function automatic logic cred_out(input logic signed [CRED_W-1:0] c);
        return c <= 0;
    endfunction

    task automatic model_step();
        logic [1:0] nstk;
        logic       stl;
        logic [2:0] cur;
        cur = m_st;
        // R7 / R8 sticky and protocol error
        m_perr[0] = exe_unblock && !m_stk[0];
        m_perr[1] = cmt_unblock && !m_stk[1];
        nstk[0] = exe_block | (m_stk[0] & ~exe_unblock);
        nstk[1] = cmt_block | (m_stk[1] & ~cmt_unblock);
        m_stk = nstk;
        stl = (|nstk) || cred_out(rob_credit) || cred_out(iq_credit) ||
              cred_out(lsq_credit) || no_free_regs ||
              (cur == S_SER && (!rob_empty || inflight != 0));
        m_blk = 0; m_unb = 0; m_rein = 0;
        if (squash_req) begin
            m_st = S_SQ; m_tag = "R2";
            if (cur == S_BLK || cur == S_UNB) begin
                m_unb = 1; m_held = 0; m_rser = 0; m_runb = (cur == S_UNB); m_tag = "R12";
            end else if ((cur == S_SER || cur == S_SQ) && m_held) begin
                m_tag = "R11";
                if (m_seq <= squash_seq) m_rser = 1;
                else begin m_rser = 0; m_held = 0; m_unb = 1; end
            end
        end else if (rob_squashing) begin
            m_st = S_SQ; m_tag = "R3";
        end else if (stl) begin
            if (cur == S_SQ && m_rser) begin
                m_st = S_SER; m_rser = 0; m_runb = 0; m_blk = 1; m_tag = "R13";
            end else if (cur == S_SER) begin
                m_tag = "R5";
            end else begin
                m_blk = !(cur == S_BLK || cur == S_UNB);
                m_tag = m_blk ? "R4" : "R5";
                m_st = S_BLK; m_runb = 0;
            end
        end else begin
            case (cur)
                S_IDLE, S_RUN: begin
                    m_tag = "R9";
                    if (ser_req) begin
                        m_st = S_SER; m_held = 1; m_seq = ser_req_seq; m_blk = 1;
                    end else if (inst_valid) m_st = S_RUN;
                end
                S_BLK: begin m_st = S_UNB; m_tag = "R6"; end
                S_UNB: begin
                    m_tag = "R6";
                    if (skid_empty) begin m_st = S_RUN; m_unb = 1; end
                end
                S_SQ: begin
                    if (m_rser) begin m_st = S_SER; m_rser = 0; m_blk = 1; m_tag = "R11"; end
                    else if (m_runb) begin m_st = S_UNB; m_runb = 0; m_blk = 1; m_tag = "R12"; end
                    else begin m_st = S_RUN; m_tag = "R3"; end
                end
                default: begin
                    m_st = S_UNB; m_rein = 1; m_rseq = m_seq; m_held = 0; m_tag = "R10";
                end
            endcase
        end
    endtask

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        check(m_tag, "state", int'(state), int'(m_st));
        check(m_tag, "up_block/up_unblock", int'({up_block, up_unblock}), int'({m_blk, m_unb}));
        check("R10", "reinsert", int'(reinsert), int'(m_rein));
        if (m_rein) check("R10", "reinsert_seq", int'(reinsert_seq), int'(m_rseq));
        check("R8", "proto_err", int'(proto_err), int'(m_perr));
    endtask

    task automatic quiet();
        squash_req = 0; squash_seq = '0; rob_squashing = 0;
        exe_block = 0; exe_unblock = 0; cmt_block = 0; cmt_unblock = 0;
        rob_credit = 8'sd4; iq_credit = 8'sd4; lsq_credit = 8'sd4;
        no_free_regs = 0; rob_empty = 1; inflight = '0; skid_empty = 1;
        inst_valid = 1; ser_req = 0; ser_req_seq = '0;
    endtask

    // one clock: model predicts, edge happens, outputs compared at negedge
    task automatic step();
        model_step();
        @(negedge clk);
        compare();
        quiet();
    endtask

    task automatic rand_inputs();
        squash_req    = ($urandom % 30) == 0;
        squash_seq    = SEQ_W'($urandom % 32);
        rob_squashing = ($urandom % 25) == 0;
        exe_block     = ($urandom % 20) == 0;
        exe_unblock   = ($urandom % 12) == 0;
        cmt_block     = ($urandom % 20) == 0;
        cmt_unblock   = ($urandom % 12) == 0;
        rob_credit    = (($urandom % 14) == 0) ? -8'sd2 : 8'sd3;
        iq_credit     = (($urandom % 14) == 0) ? 8'sd0 : 8'sd5;
        lsq_credit    = (($urandom % 20) == 0) ? 8'sd0 : 8'sd1;
        no_free_regs  = ($urandom % 25) == 0;
        rob_empty     = ($urandom % 3) != 0;
        inflight      = (($urandom % 3) == 0) ? CNT_W'($urandom % 4) : '0;
        skid_empty    = ($urandom % 2) == 0;
        inst_valid    = ($urandom % 2) == 0;
        ser_req       = ($urandom % 8) == 0;
        ser_req_seq   = SEQ_W'($urandom % 32);
    endtask

    initial begin : watchdog
        #(200000 * 10);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        quiet();
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        compare();

        // R9, R10: serialize waits for empty ROB, then reinsert and unblock
        ser_req = 1; ser_req_seq = 16'd9; step();
        rob_empty = 0; step();
        rob_empty = 1; inflight = 6'd2; step();
        step();                          // R10 exit
        skid_empty = 0; step();          // R6 stays
        step();                          // R6 to Running with unblock

        // R11: equal sequence numbers resume the serialize
        ser_req = 1; ser_req_seq = 16'd7; step();
        rob_empty = 0; step();
        squash_req = 1; squash_seq = 16'd7; step();
        step();
        // R11: younger held instruction is dropped
        squash_req = 1; squash_seq = 16'd6; step();
        step();

        // R13: resume-serialize under a stall
        ser_req = 1; ser_req_seq = 16'd3; step();
        rob_empty = 0; squash_req = 1; squash_seq = 16'd10; step();
        no_free_regs = 1; step();
        step();

        // R4, R5, R6: credit exhaustion
        rob_credit = 8'sd0; step();
        lsq_credit = -8'sd1; step();
        step();
        skid_empty = 0; step();
        rob_credit = 8'sd0; step();      // stall in Unblocking: no pulse
        step(); step();

        // R7, R8: sticky bits and protocol error
        exe_block = 1; step();
        cmt_unblock = 1; step();         // R8 error bit 1
        exe_block = 1; exe_unblock = 1; step();   // R7 block wins
        exe_unblock = 1; step();
        step(); step();

        // R12: squash in Unblocking resumes unblocking
        iq_credit = 8'sd0; step();
        skid_empty = 0; step();
        squash_req = 1; squash_seq = 16'd1; step();
        skid_empty = 0; step();
        step();
        // R3: ROB squashing holds Squashing, R2: squash over stall
        rob_squashing = 1; step();
        rob_squashing = 1; no_free_regs = 1; step();
        squash_req = 1; cmt_block = 1; step();
        cmt_unblock = 1; step();
        step(); step();

        // mixed random stimulus
        for (int i = 0; i < 4000; i++) begin
            rand_inputs();
            model_step();
            @(negedge clk);
            compare();
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule